// File: doc/BRIEF.md
# Floating-Point Deferred Trap Sequencer

This block sequences the traps of a floating-point coprocessor whose errors are reported late. When the coprocessor detects an error, the block does not trap at once. It parks the offending instruction's address and instruction word in a one-entry trap queue and moves to a pending state. The trap request to the integer unit is raised only when the next floating-point instruction (an operation, an FP load or an FP branch) is presented.

After the trap the block sits in an exception state. Any further floating-point instruction in that state is turned into a sequence error: it is recorded in the trap-type field and is not queued. The trap handler empties the queue with a store-queue request, which returns the saved address word and then the saved instruction word on two consecutive cycles. This re-arms the block. The block also owns the queue-not-empty flag, the trap-type field and a constant version field of the FP status word. The arithmetic datapath and the integer unit are outside it. A datapath that meets an operation it does not implement reports this with a raise carrying code 3.

Top module: `fpu_trap_sequencer`

## Requirements
- R1: While reset is asserted and in the cycle after it, mode_o is 0 (execute), trap_o and deq_valid_o are 0, and status_o holds only the version field.
- R2: A raise request in execute mode with queue-not-empty clear stores pc_i and insn_i in the queue. At the next edge it also sets queue-not-empty (status bit 13), copies raise_code_i into the trap-type field (status bits 16:14) and moves mode_o to 1 (pending). Codes: 0 none, 1 IEEE exception, 2 unfinished, 3 unimplemented operation, 4 sequence error, 6 invalid register.
- R3: A raise request outside execute mode, or while queue-not-empty is set, leaves the mode, the status word and the queued entry unchanged.
- R4: An FP instruction strobe in pending mode moves mode_o to 2 (exception). It also produces a trap_o pulse exactly one cycle long, visible in the cycle after the strobe.
- R5: With WIDE_KINDS=1, trap_kind_o is 1 together with the pulse when the trap type is 1 (IEEE exception) and 0 for any other type. With WIDE_KINDS=0 it is always 0.
- R6: An FP instruction strobe in exception mode sets the trap type to 4. The mode stays at 2, and the queued entry keeps the original address and instruction.
- R7: A store-queue request in execute mode with queue-not-empty clear acts as a raise with code 4, queuing that cycle's pc_i and insn_i. No dequeue words are produced.
- R8: A store-queue request with queue-not-empty set drives deq_valid_o high for two cycles: the queued address word in the cycle after the request, then the instruction word. At the second word's edge, queue-not-empty clears and mode_o returns to 0. The trap type is kept.
- R9: An FP instruction strobe in execute mode changes nothing and raises no trap.
- R10: When several requests arrive in one cycle, a store-queue request takes precedence over a raise, and a raise takes precedence over an FP strobe. The strobe is dropped even if the raise is refused. All requests presented in the cycle between the two dequeue words are ignored.
- R11: The version field (status bits 19:17) always equals the VERSION parameter, and status bits 12:0 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raise_i | input | 1 | Coprocessor reports an error |
| raise_code_i | input | 3 | Trap-type code of the error |
| fp_insn_i | input | 1 | A new FP instruction is presented |
| store_q_i | input | 1 | Request to store the trap queue |
| pc_i | input | WORD_W | Address of the current instruction |
| insn_i | input | WORD_W | Current instruction word |
| trap_o | output | 1 | One-cycle trap request to the integer unit |
| trap_kind_o | output | 1 | 1 = IEEE exception trap, 0 = other |
| deq_valid_o | output | 1 | Dequeued word valid |
| deq_data_o | output | WORD_W | Dequeued address word, then instruction word |
| mode_o | output | 2 | 0 execute, 1 pending, 2 exception |
| status_o | output | 20 | Version, trap type, queue-not-empty fields |

## Verification
The hardest situation to reach is a sequence error in exception mode followed by a queue store. A correct result there needs the original entry to have survived an FP strobe that must not enqueue. It also needs the trap type from the strobe to outlive the drain. The bench reaches it for every trap-type code by walking a raise, a trapping strobe, a second strobe and a store in turn. It adds a raise and an FP strobe during the store to hit the precedence and busy-cycle rules in the same pass.

// File: rtl/fts_pkg.sv
package fts_pkg;
  parameter int FTT_W = 3;

  typedef enum logic [1:0] {
    MODE_EXEC = 2'd0,
    MODE_PEND = 2'd1,
    MODE_EXC  = 2'd2
  } fts_mode_e;

  localparam logic [FTT_W-1:0] FTT_NONE = 3'd0;
  localparam logic [FTT_W-1:0] FTT_IEEE = 3'd1;
  localparam logic [FTT_W-1:0] FTT_SEQ  = 3'd4;

  // status word layout
  localparam int QNE_BIT = 13;
  localparam int FTT_LSB = 14;
  localparam int VER_LSB = FTT_LSB + FTT_W;
endpackage

// File: rtl/fts_mode_ctl.sv
module fts_mode_ctl
  import fts_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             raise_i,
  input  logic [FTT_W-1:0] code_i,
  input  logic             fp_i,
  input  logic             store_i,
  output fts_mode_e        mode_o,
  output logic             qne_o,
  output logic [FTT_W-1:0] ftt_o,
  output logic             capture_o,
  output logic             rd_en_o,
  output logic             rd_sel_o,
  output logic             fire_o
);
  fts_mode_e        mode_q;
  logic             qne_q;
  logic [FTT_W-1:0] ftt_q;
  logic             drain_q;

  logic st_ok, st_drain, st_seq, rz, fp_ev, seqerr;

  always_comb begin
    st_ok     = store_i && !drain_q;
    st_drain  = st_ok && qne_q;
    st_seq    = st_ok && !qne_q && (mode_q == MODE_EXEC);
    rz        = raise_i && !drain_q && !store_i && (mode_q == MODE_EXEC) && !qne_q;
    fp_ev     = fp_i && !drain_q && !store_i && !raise_i;
    fire_o    = fp_ev && (mode_q == MODE_PEND);
    seqerr    = fp_ev && (mode_q == MODE_EXC);
    capture_o = st_seq || rz;
    rd_en_o   = st_drain || drain_q;
    rd_sel_o  = drain_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_EXEC;
      qne_q   <= 1'b0;
      ftt_q   <= FTT_NONE;
      drain_q <= 1'b0;
    end else if (drain_q) begin
      drain_q <= 1'b0;
      qne_q   <= 1'b0;
      mode_q  <= MODE_EXEC;
    end else if (st_drain) begin
      drain_q <= 1'b1;
    end else if (capture_o) begin
      qne_q  <= 1'b1;
      ftt_q  <= st_seq ? FTT_SEQ : code_i;
      mode_q <= MODE_PEND;
    end else if (fire_o) begin
      mode_q <= MODE_EXC;
    end else if (seqerr) begin
      ftt_q <= FTT_SEQ;
    end
  end

  assign mode_o = mode_q;
  assign qne_o  = qne_q;
  assign ftt_o  = ftt_q;
endmodule

// File: rtl/fts_queue.sv
module fts_queue #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture_i,
  input  logic [WORD_W-1:0] pc_i,
  input  logic [WORD_W-1:0] insn_i,
  input  logic              rd_en_i,
  input  logic              rd_sel_i,
  output logic              deq_valid_o,
  output logic [WORD_W-1:0] deq_data_o
);
  logic [WORD_W-1:0] addr_q, insn_q;

  always_ff @(posedge clk) begin
    if (capture_i) begin
      addr_q <= pc_i;
      insn_q <= insn_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      deq_valid_o <= 1'b0;
      deq_data_o  <= '0;
    end else begin
      deq_valid_o <= rd_en_i;
      if (rd_en_i) deq_data_o <= rd_sel_i ? insn_q : addr_q;
    end
  end
endmodule

// File: rtl/fts_trap_gen.sv
module fts_trap_gen
  import fts_pkg::*;
#(
  parameter bit WIDE_KINDS = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire_i,
  input  logic [FTT_W-1:0] ftt_i,
  output logic             trap_o,
  output logic             kind_o
);
  logic kind_n;

  generate
    if (WIDE_KINDS) begin : g_two_kinds
      assign kind_n = (ftt_i == FTT_IEEE);
    end else begin : g_one_kind
      assign kind_n = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_o <= 1'b0;
      kind_o <= 1'b0;
    end else begin
      trap_o <= fire_i;
      if (fire_i) kind_o <= kind_n;
    end
  end
endmodule

// File: rtl/fpu_trap_sequencer.sv
module fpu_trap_sequencer
  import fts_pkg::*;
#(
  parameter int              WORD_W     = 32,
  parameter int              VER_W      = 3,
  parameter logic [VER_W-1:0] VERSION   = 3'd5,
  parameter bit              WIDE_KINDS = 1'b1,
  localparam int             ST_W       = VER_LSB + VER_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              raise_i,
  input  logic [FTT_W-1:0]  raise_code_i,
  input  logic              fp_insn_i,
  input  logic              store_q_i,
  input  logic [WORD_W-1:0] pc_i,
  input  logic [WORD_W-1:0] insn_i,
  output logic              trap_o,
  output logic              trap_kind_o,
  output logic              deq_valid_o,
  output logic [WORD_W-1:0] deq_data_o,
  output logic [1:0]        mode_o,
  output logic [ST_W-1:0]   status_o
);
  fts_mode_e        mode;
  logic             qne;
  logic [FTT_W-1:0] ftt;
  logic             capture, rd_en, rd_sel, fire;

  fts_mode_ctl u_ctl (
    .clk(clk), .rst(rst), .raise_i(raise_i), .code_i(raise_code_i),
    .fp_i(fp_insn_i), .store_i(store_q_i), .mode_o(mode), .qne_o(qne),
    .ftt_o(ftt), .capture_o(capture), .rd_en_o(rd_en), .rd_sel_o(rd_sel),
    .fire_o(fire)
  );

  fts_queue #(.WORD_W(WORD_W)) u_q (
    .clk(clk), .rst(rst), .capture_i(capture), .pc_i(pc_i), .insn_i(insn_i),
    .rd_en_i(rd_en), .rd_sel_i(rd_sel), .deq_valid_o(deq_valid_o),
    .deq_data_o(deq_data_o)
  );

  fts_trap_gen #(.WIDE_KINDS(WIDE_KINDS)) u_trap (
    .clk(clk), .rst(rst), .fire_i(fire), .ftt_i(ftt),
    .trap_o(trap_o), .kind_o(trap_kind_o)
  );

  always_comb begin
    status_o = '0;
    status_o[QNE_BIT] = qne;
    status_o[FTT_LSB +: FTT_W] = ftt;
    status_o[VER_LSB +: VER_W] = VERSION;
  end

  assign mode_o = mode;
endmodule

// File: rtl/fts_checker.sv
module fts_checker
  import fts_pkg::*;
#(
  parameter int               VER_W   = 3,
  parameter logic [VER_W-1:0] VERSION = 3'd5,
  parameter int               ST_W    = VER_LSB + VER_W
) (
  input logic            clk,
  input logic            rst,
  input logic            trap_o,
  input logic            deq_valid_o,
  input logic [1:0]      mode_o,
  input logic [ST_W-1:0] status_o
);
  // R4
  trap_single_chk: assert property (@(posedge clk) disable iff (rst)
    trap_o |=> !trap_o);
  // R4
  trap_mode_chk: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> (mode_o == 2'd2));
  // R2
  mode_code_chk: assert property (@(posedge clk) disable iff (rst)
    mode_o != 2'd3);
  // R6
  busy_qne_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_o != 2'd0) |-> status_o[QNE_BIT]);
  // R8
  deq_pair_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(deq_valid_o) |=> deq_valid_o);
  // R8
  deq_end_chk: assert property (@(posedge clk) disable iff (rst)
    (deq_valid_o && $past(deq_valid_o)) |=> !deq_valid_o);
  // R8
  deq_rearm_chk: assert property (@(posedge clk) disable iff (rst)
    (deq_valid_o && $past(deq_valid_o)) |-> (!status_o[QNE_BIT] && mode_o == 2'd0));
  // R11
  version_chk: assert property (@(posedge clk) disable iff (rst)
    status_o[VER_LSB +: VER_W] == VERSION);
endmodule

bind fpu_trap_sequencer fts_checker #(.VER_W(VER_W), .VERSION(VERSION)) u_chk (
  .clk(clk), .rst(rst), .trap_o(trap_o), .deq_valid_o(deq_valid_o),
  .mode_o(mode_o), .status_o(status_o)
);

// File: tb/sim_fpu_trap_sequencer.sv
module sim_fpu_trap_sequencer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic raise = 1'b0, fp = 1'b0, stq = 1'b0;
  logic [2:0] code = '0;
  logic [31:0] pc = '0, insn = '0;

  logic trap0, kind0, dv0; logic [31:0] dd0; logic [1:0] md0; logic [19:0] st0;
  logic trap1, kind1, dv1; logic [31:0] dd1; logic [1:0] md1; logic [19:0] st1;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fpu_trap_sequencer #(.WIDE_KINDS(1'b1)) u0 (
    .clk(clk), .rst(rst), .raise_i(raise), .raise_code_i(code), .fp_insn_i(fp),
    .store_q_i(stq), .pc_i(pc), .insn_i(insn), .trap_o(trap0), .trap_kind_o(kind0),
    .deq_valid_o(dv0), .deq_data_o(dd0), .mode_o(md0), .status_o(st0));

  fpu_trap_sequencer #(.WIDE_KINDS(1'b0)) u1 (
    .clk(clk), .rst(rst), .raise_i(raise), .raise_code_i(code), .fp_insn_i(fp),
    .store_q_i(stq), .pc_i(pc), .insn_i(insn), .trap_o(trap1), .trap_kind_o(kind1),
    .deq_valid_o(dv1), .deq_data_o(dd1), .mode_o(md1), .status_o(st1));

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string r, input logic [63:0] a, input logic [63:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, a, e);
    end
  endtask

  task automatic idle();
    raise = 0; fp = 0; stq = 0;
  endtask

  // expected status: version 5 at 19:17, type at 16:14, queue flag at 13
  function automatic logic [19:0] exp_st(input logic q, input logic [2:0] t);
    return (20'd5 << 17) | (20'(t) << 14) | (20'(q) << 13);
  endfunction

  initial begin
    tick(); tick();
    chk("R1 mode in reset", md0, 0);
    chk("R1 status in reset", st0, exp_st(0, 0));
    chk("R1 trap in reset", trap0, 0);
    rst = 0; tick();
    chk("R1 deq after reset", dv0, 0);
    chk("R11 status after reset", st0, exp_st(0, 0));

    // R9: FP strobe in execute does nothing
    fp = 1; tick(); idle();
    chk("R9 mode", md0, 0); chk("R9 trap", trap0, 0);
    chk("R9 status", st0, exp_st(0, 0));

    // R7: store with empty queue -> sequence error
    stq = 1; pc = 32'h0000_0bad; insn = 32'hdead_0001; tick(); idle();
    chk("R7 mode", md0, 1); chk("R7 status", st0, exp_st(1, 4));
    chk("R7 no deq", dv0, 0);
    stq = 1; tick(); idle();
    chk("R8 word0 valid", dv0, 1); chk("R8 word0 data (R7 entry)", dd0, 32'h0000_0bad);
    tick();
    chk("R8 word1 data (R7 entry)", dd0, 32'hdead_0001);
    chk("R8 rearm", st0, exp_st(0, 4)); chk("R8 mode", md0, 0);
    tick();
    chk("R8 deq ends", dv0, 0);

    for (int c = 0; c < 8; c++) begin
      // R10: raise wins over FP strobe in execute
      raise = 1; fp = 1; code = 3'(c);
      pc = 32'h1000 + c; insn = 32'ha000_0000 | c; tick(); idle();
      chk("R2 mode", md0, 1); chk("R2 status", st0, exp_st(1, 3'(c)));
      chk("R10 no trap", trap0, 0);
      // R3: raise when pending ignored
      raise = 1; code = 3'(c + 1); pc = 32'h9999; insn = 32'h8888; tick(); idle();
      chk("R3 pending ignored", st0, exp_st(1, 3'(c)));
      chk("R3 mode", md0, 1);
      // R4/R5
      fp = 1; tick(); idle();
      chk("R4 trap pulse", trap0, 1); chk("R4 mode", md0, 2);
      chk("R5 wide kind", kind0, (c == 1) ? 1 : 0);
      chk("R5 narrow kind", kind1, 0);
      tick();
      chk("R4 pulse ends", trap0, 0);
      // R3 in exception
      raise = 1; code = 3'd2; tick(); idle();
      chk("R3 exception ignored", st0, exp_st(1, 3'(c)));
      // R6
      fp = 1; pc = 32'h7777; insn = 32'h6666; tick(); idle();
      chk("R6 seq error", st0, exp_st(1, 4)); chk("R6 mode", md0, 2);
      chk("R6 no trap", trap0, 0);
      // R10: store wins over raise; busy-cycle inputs ignored
      stq = 1; raise = 1; fp = 1; tick();
      chk("R8 word0", dd0, 32'h1000 + c); chk("R8 valid0", dv0, 1);
      stq = 1; raise = 1; fp = 1; code = 3'd1; tick(); idle();
      chk("R6 entry kept", dd0, 32'ha000_0000 | c); chk("R8 valid1", dv0, 1);
      chk("R10 busy ignored", st0, exp_st(0, 4)); chk("R8 mode back", md0, 0);
      tick();
      chk("R10 no trap after busy", trap0, 0);
      chk("R10 still execute", md0, 0);
    end

    // R8: store straight from pending
    raise = 1; code = 3'd3; pc = 32'h4242; insn = 32'h2424; tick(); idle();
    stq = 1; tick(); idle();
    chk("R8 pending store word0", dd0, 32'h4242);
    tick();
    chk("R8 pending store word1", dd0, 32'h2424);
    chk("R8 pending store rearm", st0, exp_st(0, 3));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule